// File: doc/BRIEF.md
# Wide Block Memory Copy Engine

This block moves a run of bytes from one place in memory to another, handling the whole run as one command with the loop kept entirely in hardware. Memory is reached through a single synchronous port that is one line (16 bytes at the default width) wide. The engine takes one line read and one line write in each pair of cycles, so it sustains half a line per cycle. Per-lane write enables keep the first and last line writes inside the requested byte range.

Source and destination may sit at different offsets within their lines. In that case a holding register keeps the previous line read, and a byte rotator joins it with the current line read to form each destination line. One extra read at the start fills the holding register. A host starts a copy with a one-cycle `start` pulse carrying the source address, destination address and byte count. It then watches `busy` and the one-cycle `done` pulse.

The memory port has fixed timing and no back-pressure: a read issued in one cycle returns its data in the next cycle, and a write takes effect at the clock edge that ends its cycle. Both are always accepted. The command input has no ready signal: a `start` pulse is taken only while the engine is idle.

Top module: `wide_copy_engine`

## Requirements
- R1: Each cycle the memory port makes at most one access, a read (`mem_rd`) or a write (`mem_wr`) but never both. `mem_addr` is a line address (byte address divided by the line size), and read data is taken from `mem_rdata` one cycle after the read.
- R2: Every write is issued in the cycle right after a read. The writes of one command go to consecutive ascending lines, starting at the line holding the destination address, and there is one write per destination line touched.
- R3: On the first write of a command, lane j of `mem_be` (byte j of the line, bits 8j+7..8j of the data) is enabled only if j is at least the destination's byte offset within its line.
- R4: On the last write, lane j is enabled only if j is at most (dst + count - 1) mod line size. When the first and last writes are the same beat, both limits apply together, and every write enables at least one lane.
- R5: After the command, every destination byte dst+i (0 <= i < count) holds the byte that was at src+i, whatever the two line offsets are. Every other memory byte is unchanged.
- R6: For N destination lines, `busy` is high for exactly 2N cycles when src and dst share the same offset within a line, and for 2N+1 cycles otherwise.
- R7: A command with count 0 makes no memory access, keeps `busy` low, and pulses `done` in the next cycle.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The running copy, its timing and memory are unaffected.
- R9: `done` is high for exactly one cycle: the first cycle after the final write, when `busy` has already dropped.
- R10: During and right after reset, `busy`, `done`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle command pulse, taken only while idle |
| src_addr | input | ADDR_W | Byte address of the first source byte |
| dst_addr | input | ADDR_W | Byte address of the first destination byte |
| byte_count | input | LEN_W | Number of bytes to copy |
| busy | output | 1 | High while a copy is in progress |
| done | output | 1 | One-cycle pulse after a copy ends |
| mem_addr | output | ADDR_W-log2(DATA_W/8) | Line address of the current access |
| mem_rd | output | 1 | Read strobe, data returned next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_be | output | DATA_W/8 | Per-lane write enables |
| mem_wdata | output | DATA_W | Line write data |
| mem_rdata | input | DATA_W | Line read data, valid one cycle after the read |

## Verification
A bad beat counter or line pointer shows at the port within one access. It produces a write to a line out of sequence, or a `busy` window whose length differs from 2N or 2N+1 cycles. A stale or wrongly loaded holding register, or a wrong rotate amount, changes no timing at all. It shows only as wrong bytes in the destination once the write of the affected beat lands, so the bench compares the whole memory image after every command. A mask fault shows on the first or last write, either as an enable pattern that differs from the requested range or as corrupted bytes next to the range.

// File: rtl/wcopy_pkg.sv
package wcopy_pkg;
  typedef enum logic [1:0] {
    WC_IDLE  = 2'd0,
    WC_PRIME = 2'd1,
    WC_RD    = 2'd2,
    WC_WR    = 2'd3
  } wc_state_e;
endpackage

// File: rtl/wcopy_ctrl.sv
module wcopy_ctrl
  import wcopy_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int OFF_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        src_addr,
  input  logic [ADDR_W-1:0]        dst_addr,
  input  logic [LEN_W-1:0]         byte_count,
  output logic                     busy,
  output logic                     done,
  output logic [ADDR_W-OFF_W-1:0]  line_addr,
  output logic                     rd_en,
  output logic                     wr_en,
  output logic                     first_beat,
  output logic                     last_beat,
  output logic [OFF_W-1:0]         head_off,
  output logic [OFF_W-1:0]         tail_off,
  output logic [OFF_W-1:0]         shift,
  output logic                     hold_load
);
  localparam int LINE_W = ADDR_W - OFF_W;

  wc_state_e          state;
  logic [LINE_W-1:0]  src_line;
  logic [LINE_W-1:0]  dst_line;
  logic [LEN_W-1:0]   beats_left;
  logic               primed;

  // command decode, combinational from the start fields
  logic [ADDR_W-1:0]  end_byte;
  logic [ADDR_W-1:0]  src_base;
  logic [LINE_W-1:0]  span;
  logic [LEN_W-1:0]   nbeats;

  always_comb begin
    end_byte = dst_addr + ADDR_W'(byte_count) - ADDR_W'(1);
    src_base = src_addr - ADDR_W'(dst_addr[OFF_W-1:0]);
    span     = end_byte[ADDR_W-1:OFF_W] - dst_addr[ADDR_W-1:OFF_W];
    nbeats   = LEN_W'(span) + LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= WC_IDLE;
      done       <= 1'b0;
      src_line   <= '0;
      dst_line   <= '0;
      beats_left <= '0;
      primed     <= 1'b0;
      first_beat <= 1'b0;
      head_off   <= '0;
      tail_off   <= '0;
      shift      <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        WC_IDLE: begin
          if (start) begin
            if (byte_count == '0) begin
              done <= 1'b1;
            end else begin
              head_off   <= dst_addr[OFF_W-1:0];
              tail_off   <= end_byte[OFF_W-1:0];
              shift      <= src_base[OFF_W-1:0];
              src_line   <= src_base[ADDR_W-1:OFF_W];
              dst_line   <= dst_addr[ADDR_W-1:OFF_W];
              beats_left <= nbeats;
              first_beat <= 1'b1;
              primed     <= 1'b0;
              state      <= (src_base[OFF_W-1:0] != '0) ? WC_PRIME : WC_RD;
            end
          end
        end
        WC_PRIME: begin
          src_line <= src_line + LINE_W'(1);
          primed   <= 1'b1;
          state    <= WC_RD;
        end
        WC_RD: begin
          src_line <= src_line + LINE_W'(1);
          primed   <= 1'b0;
          state    <= WC_WR;
        end
        WC_WR: begin
          dst_line   <= dst_line + LINE_W'(1);
          beats_left <= beats_left - LEN_W'(1);
          first_beat <= 1'b0;
          if (beats_left == LEN_W'(1)) begin
            state <= WC_IDLE;
            done  <= 1'b1;
          end else begin
            state <= WC_RD;
          end
        end
        default: state <= WC_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != WC_IDLE);
    rd_en     = (state == WC_PRIME) || (state == WC_RD);
    wr_en     = (state == WC_WR);
    line_addr = wr_en ? dst_line : src_line;
    last_beat = (beats_left == LEN_W'(1));
    // capture the priming read, and every paired read when realigning
    hold_load = ((state == WC_RD) && primed) ||
                ((state == WC_WR) && (shift != '0));
  end
endmodule

// File: rtl/wcopy_lane_mask.sv
module wcopy_lane_mask #(
  parameter int LANES = 16,
  parameter int OFF_W = 4
) (
  input  logic             first_beat,
  input  logic             last_beat,
  input  logic [OFF_W-1:0] head_off,
  input  logic [OFF_W-1:0] tail_off,
  output logic [LANES-1:0] lane_en
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic head_ok;
    logic tail_ok;
    assign head_ok    = !first_beat || (OFF_W'(j) >= head_off);
    assign tail_ok    = !last_beat  || (OFF_W'(j) <= tail_off);
    assign lane_en[j] = head_ok && tail_ok;
  end
endmodule

// File: rtl/wcopy_align.sv
module wcopy_align #(
  parameter int DATA_W = 128,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_load,
  input  logic [OFF_W-1:0]  shift,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wdata
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (!rst_n)         hold <= '0;
    else if (hold_load) hold <= rdata;
  end

  // lane j takes byte (j + shift) of the pair {current, previous}
  logic [7:0] pool [2*LANES];
  for (genvar k = 0; k < LANES; k++) begin : g_pool
    assign pool[k]         = hold[8*k +: 8];
    assign pool[k + LANES] = rdata[8*k +: 8];
  end

  for (genvar j = 0; j < LANES; j++) begin : g_out
    logic [OFF_W:0] idx;
    assign idx = (OFF_W+1)'(j) + {1'b0, shift};
    assign wdata[8*j +: 8] = (shift == '0) ? rdata[8*j +: 8] : pool[idx];
  end
endmodule

// File: rtl/wide_copy_engine.sv
module wide_copy_engine #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 128
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  input  logic [ADDR_W-1:0]                      src_addr,
  input  logic [ADDR_W-1:0]                      dst_addr,
  input  logic [LEN_W-1:0]                       byte_count,
  output logic                                   busy,
  output logic                                   done,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]     mem_addr,
  output logic                                   mem_rd,
  output logic                                   mem_wr,
  output logic [DATA_W/8-1:0]                    mem_be,
  output logic [DATA_W-1:0]                      mem_wdata,
  input  logic [DATA_W-1:0]                      mem_rdata
);
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int LINE_W = ADDR_W - OFF_W;

  logic             first_beat;
  logic             last_beat;
  logic [OFF_W-1:0] head_off;
  logic [OFF_W-1:0] tail_off;
  logic [OFF_W-1:0] shift;
  logic             hold_load;
  logic             wr_en;
  logic [LANES-1:0] lane_en;

  wcopy_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .byte_count (byte_count),
    .busy       (busy),
    .done       (done),
    .line_addr  (mem_addr),
    .rd_en      (mem_rd),
    .wr_en      (wr_en),
    .first_beat (first_beat),
    .last_beat  (last_beat),
    .head_off   (head_off),
    .tail_off   (tail_off),
    .shift      (shift),
    .hold_load  (hold_load)
  );

  wcopy_lane_mask #(.LANES(LANES), .OFF_W(OFF_W)) u_mask (
    .first_beat (first_beat),
    .last_beat  (last_beat),
    .head_off   (head_off),
    .tail_off   (tail_off),
    .lane_en    (lane_en)
  );

  wcopy_align #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_load (hold_load),
    .shift     (shift),
    .rdata     (mem_rdata),
    .wdata     (mem_wdata)
  );

  assign mem_wr = wr_en;
  assign mem_be = wr_en ? lane_en : '0;
endmodule

// File: rtl/wcopy_checker.sv
module wcopy_checker #(
  parameter int LINE_W = 28,
  parameter int LANES  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [LINE_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [LANES-1:0]  mem_be
);
  a_r1_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r2_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));

  a_r2_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr, 2)) |-> (mem_addr == $past(mem_addr, 2) + LINE_W'(1)));

  a_r4_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_be != '0));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) || $past(start)));
endmodule

bind wide_copy_engine wcopy_checker #(.LINE_W(LINE_W), .LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_be   (mem_be)
);

// File: tb/wide_copy_engine_tb.sv
`timescale 1ns/1ps
module wide_copy_engine_tb;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int DATA_W = 128;
  localparam int LANES  = DATA_W / 8;
  localparam int LINE_W = ADDR_W - 4;
  localparam int MEMB   = 1024;
  localparam int NVEC   = 12;

  localparam int VSRC [NVEC] = '{0,   3,   5,   0,   7,   17,  31,  40,  100, 250, 1,   15};
  localparam int VDST [NVEC] = '{512, 515, 520, 512, 530, 600, 513, 527, 700, 800, 640, 641};
  localparam int VCNT [NVEC] = '{16,  13,  1,   64,  40,  100, 2,   2,   99,  50,  15,  100};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] src_addr = '0;
  logic [ADDR_W-1:0] dst_addr = '0;
  logic [LEN_W-1:0]  byte_count = '0;
  logic              busy, done, mem_rd, mem_wr;
  logic [LINE_W-1:0] mem_addr;
  logic [LANES-1:0]  mem_be;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata = '0;

  logic [7:0] mem    [MEMB];
  logic [7:0] refmem [MEMB];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wide_copy_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
    .dst_addr(dst_addr), .byte_count(byte_count), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // line-wide memory, one-cycle read latency, per-lane write enables
  always @(posedge clk) begin
    if (mem_rd)
      for (int j = 0; j < LANES; j++)
        mem_rdata[8*j +: 8] <= mem[{mem_addr[5:0], 4'(j)}];
    if (mem_wr)
      for (int j = 0; j < LANES; j++)
        if (mem_be[j]) mem[{mem_addr[5:0], 4'(j)}] <= mem_wdata[8*j +: 8];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int s, input int d, input int c, input int seed, input bit poke);
    int cyc = 0;
    int nb, pr, wbeat = 0;
    bit excl_bad = 0, seq_bad = 0, mask_bad = 0;
    longint seq_act = 0, seq_exp = 0, mask_act = 0, mask_exp = 0;
    int bad_idx = -1;
    for (int i = 0; i < MEMB; i++) begin
      mem[i]    = 8'(i * 37 + seed * 11 + 5);
      refmem[i] = 8'(i * 37 + seed * 11 + 5);
    end
    for (int i = 0; i < c; i++) refmem[(d + i) % MEMB] = refmem[(s + i) % MEMB];
    nb = (c == 0) ? 0 : ((d + c - 1) / 16 - d / 16 + 1);
    pr = (((s - d) & 15) != 0) ? 1 : 0;
    @(negedge clk);
    src_addr = ADDR_W'(s); dst_addr = ADDR_W'(d); byte_count = LEN_W'(c); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && cyc < 2000) begin
      if (mem_rd && mem_wr) excl_bad = 1;
      if (mem_wr) begin
        logic [LANES-1:0] em;
        int ln = d / 16 + wbeat;
        for (int j = 0; j < LANES; j++) em[j] = (ln * 16 + j >= d) && (ln * 16 + j < d + c);
        if (mem_addr != LINE_W'(ln) && !seq_bad) begin
          seq_bad = 1; seq_act = longint'(mem_addr); seq_exp = ln;
        end
        if (mem_be != em && !mask_bad) begin
          mask_bad = 1; mask_act = longint'(mem_be); mask_exp = longint'(em);
        end
        wbeat++;
      end
      if (poke && cyc == 2) begin
        src_addr = 0; dst_addr = 32'd520; byte_count = 7; start = 1'b1;
      end
      if (poke && cyc == 3) start = 1'b0;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b1, "R9 done after last write", longint'(done), 1);
    chk(cyc == 2 * nb + ((c == 0) ? 0 : pr), poke ? "R6 R8 busy cycles" : "R6 busy cycles",
        cyc, 2 * nb + ((c == 0) ? 0 : pr));
    chk(!excl_bad, "R1 read/write exclusive", excl_bad, 0);
    chk(!seq_bad && wbeat == nb, "R2 write line sequence", seq_bad ? seq_act : wbeat,
        seq_bad ? seq_exp : nb);
    chk(!mask_bad, "R3 R4 lane enables", mask_act, mask_exp);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", longint'(done), 0);
    for (int i = 0; i < MEMB; i++)
      if (mem[i] != refmem[i] && bad_idx < 0) bad_idx = i;
    chk(bad_idx < 0, poke ? "R5 R8 memory image" : "R5 memory image",
        (bad_idx < 0) ? 0 : longint'(mem[bad_idx]),
        (bad_idx < 0) ? 0 : longint'(refmem[bad_idx]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, "R10 reset quiet",
        {busy, done, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, "R10 after reset",
        {busy, done, mem_rd, mem_wr}, 0);

    for (int v = 0; v < NVEC; v++) run(VSRC[v], VDST[v], VCNT[v], v, 1'b0);

    for (int k = 0; k < 30; k++) begin
      int s, d, c;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s = int'(lfsr) % 300;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      d = 512 + int'(lfsr) % 300;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      c = int'(lfsr) % 101;
      run(s, d, c, 20 + k, 1'b0);
    end

    // R7: zero-length command
    run(9, 600, 0, 90, 1'b0);
    @(negedge clk);
    src_addr = 4; dst_addr = 700; byte_count = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && !busy && !mem_rd && !mem_wr, "R7 zero count",
        {done, busy, mem_rd, mem_wr}, 4'b1000);

    // R8: start pulses while busy are ignored
    run(21, 610, 70, 91, 1'b1);
    run(16, 608, 48, 92, 1'b1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule